// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

This block is a general-purpose pin controller. It sits on a 32-bit single-access slave bus. Software uses it to drive a set of output pads and to enable or disable each pad's driver. Any pad can be handed over to a hardware auxiliary source instead of the software output value. The pin levels are sampled into a readable register. Sampling normally runs every bus clock. It can instead run only on the rising or the falling edge of an external capture clock, and that clock is brought into the bus clock domain by a synchronizer chain.

Each pin can report a transition as an interrupt event. A per-pin polarity bit chooses whether a rise or a fall counts, and a per-pin enable decides whether the event is recorded. Recorded events collect in a sticky pending register. A single interrupt request is raised while the global enable is set and any event is pending. Software clears pending bits by writing the pending register.

Top module: `pbk_top`

Register word offsets, decoded on byte address bits [4:2] with bits [1:0] zero:

| Offset | Register | Access |
|---|---|---|
| 0x00 | sampled pins | read-only |
| 0x04 | output value | read/write |
| 0x08 | driver enable | read/write |
| 0x0C | per-pin event enable | read/write |
| 0x10 | event polarity | read/write |
| 0x14 | auxiliary select | read/write |
| 0x18 | mode | read/write |
| 0x1C | pending events | read/write |

Mode register bits:

| Bit | Meaning |
|---|---|
| 0 | external capture clock |
| 1 | falling-edge capture |
| 2 | global interrupt enable |
| 3 | any event pending (read-only) |

## Requirements
- R1: After reset, every register reads zero, pad_o is all zeros, pad_oe_n is all ones, irq is low, and neither bus_ack nor bus_err is high.
- R2: A request (bus_cyc and bus_stb both high) is answered by exactly one of bus_ack or bus_err, one clock later. bus_err is used when the byte address has nonzero bits [1:0], or when its word index is 8 or more (offset 0x20 and up).
- R3: A write changes only the bytes whose bus_sel bit is set. bus_sel[k] covers data bits [8k+7:8k].
- R4: pad_oe_n is the bitwise inverse of the driver-enable register at offset 0x08.
- R5: For each pin, pad_o takes aux_i when that pin's auxiliary-select bit (offset 0x14) is 1, and takes the output-value bit (offset 0x04) when it is 0.
- R6: With mode bit 0 clear, the sampled-pins register at offset 0x00 takes the value of pin_i on every bus clock.
- R7: With mode bit 0 set and mode bit 1 clear, the sampled register takes pin_i only when a rising edge of ext_clk has passed through the synchronizer. Without such an edge it holds its value, even when pin_i changes.
- R8: With mode bits 0 and 1 both set, the sampled register takes pin_i only on a synchronized falling edge of ext_clk.
- R9: A change of a sampled bit sets that pin's pending bit only when the pin's event-enable bit is 1. With polarity bit 1 a 0-to-1 change counts; with polarity bit 0 a 1-to-0 change counts.
- R10: A pending bit stays set until software writes the pending register. The written value replaces the pending bits, and an event arriving in the same cycle still sets its bit.
- R11: irq is high exactly when mode bit 2 is set and some pending bit is set. irq rises within three clocks of a pin change. Writing the mode register with bit 2 clear drops irq on the next cycle, and irq stays low afterwards. Mode bit 3 reads as "any pending bit set".
- R12: Writes to the sampled-pins register at offset 0x00 are acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Transfer strobe |
| bus_we | input | 1 | Write when high |
| bus_adr | input | ADR_W | Byte address |
| bus_sel | input | 4 | Byte lane selects |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access to an unmapped or misaligned address |
| irq | output | 1 | Interrupt request |
| pin_i | input | NPINS | Pin input levels |
| aux_i | input | NPINS | Auxiliary output sources |
| ext_clk | input | 1 | External capture clock |
| pad_o | output | NPINS | Pad output values |
| pad_oe_n | output | NPINS | Pad driver enables, active low |

## Verification
The hardest case to reach from the ports is external-clock capture. The capture clock is asynchronous to the bus, and its edges only act after they pass through the synchronizer. The stimulus therefore holds each ext_clk level for several bus clocks, and it changes pin_i between edges without an edge in between, so that the read-back shows capture on the chosen edge only. Polarity filtering is covered by one event sequence that mixes enabled and disabled pins with both polarities. A pin whose transition does not match its polarity is then seen, through the pending register, to leave its bit clear.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

   typedef enum logic [2:0] {
      RG_SAMPLE = 3'd0,
      RG_DRIVE  = 3'd1,
      RG_ENABLE = 3'd2,
      RG_IEN    = 3'd3,
      RG_RISE   = 3'd4,
      RG_ALT    = 3'd5,
      RG_MODE   = 3'd6,
      RG_PEND   = 3'd7
   } reg_idx_t;

   localparam int MB_EXT  = 0;
   localparam int MB_FALL = 1;
   localparam int MB_IE   = 2;
   localparam int MB_FLAG = 3;
   localparam int MODE_W  = 3;

endpackage

// File: rtl/pbk_capture.sv
module pbk_capture #(
   parameter int NPINS       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ext_mode,
   input  logic             fall_mode,
   input  logic             ext_clk,
   input  logic [NPINS-1:0] pin_i,
   output logic [NPINS-1:0] smp_o
);

   localparam int SH_W = SYNC_STAGES + 1;

   logic [SH_W-1:0] sh_q;
   logic            sync_lvl, sync_prev, edge_hit;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pbk_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[SH_W-2:0], ext_clk};
   end

   assign sync_lvl  = sh_q[SYNC_STAGES-1];
   assign sync_prev = sh_q[SYNC_STAGES];
   assign edge_hit  = fall_mode ? (!sync_lvl && sync_prev) : (sync_lvl && !sync_prev);

   always_ff @(posedge clk) begin
      if (rst)                       smp_o <= '0;
      else if (!ext_mode || edge_hit) smp_o <= pin_i;
   end

   // R7 / R8: no synchronized edge in external mode means no capture
   p_hold_no_edge_r7: assert property (@(posedge clk) disable iff (rst)
      (ext_mode && !edge_hit) |=> $stable(smp_o));

   // R6: bus-clock mode tracks the pins one clock later
   p_follow_pins_r6: assert property (@(posedge clk) disable iff (rst)
      !ext_mode |=> (smp_o == $past(pin_i)));

endmodule

// File: rtl/pbk_events.sv
module pbk_events #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NPINS-1:0] smp,
   input  logic [NPINS-1:0] ien,
   input  logic [NPINS-1:0] rise,
   input  logic             pend_we,
   input  logic [NPINS-1:0] pend_wval,
   output logic [NPINS-1:0] pend
);

   logic [NPINS-1:0] prev_q, hit;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= smp;
   end

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         logic went_up, went_down;
         assign went_up   = smp[i] && !prev_q[i];
         assign went_down = !smp[i] && prev_q[i];
         assign hit[i]    = ien[i] && (rise[i] ? went_up : went_down);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pend <= '0;
      else     pend <= (pend_we ? pend_wval : pend) | hit;
   end

   // R10: pending bits survive while no write hits the register
   p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      !pend_we |=> ((pend & $past(pend)) == $past(pend)));

   // R9: an accepted event always lands in the pending register
   p_event_sets_r9: assert property (@(posedge clk) disable iff (rst)
      (|hit) |=> ((pend & $past(hit)) == $past(hit)));

endmodule

// File: rtl/pbk_regs.sv
module pbk_regs
   import pbk_pkg::*;
#(
   parameter int NPINS = 16,
   parameter int ADR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [ADR_W-1:0]  bus_adr,
   input  logic [3:0]        bus_sel,
   input  logic [31:0]       bus_wdat,
   output logic [31:0]       bus_rdat,
   output logic              bus_ack,
   output logic              bus_err,
   input  logic [NPINS-1:0]  smp,
   input  logic [NPINS-1:0]  pend,
   output logic [NPINS-1:0]  drive_q,
   output logic [NPINS-1:0]  enable_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  rise_q,
   output logic [NPINS-1:0]  alt_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              pend_we,
   output logic [NPINS-1:0]  pend_wval
);

   localparam int WIDX_W = ADR_W - 2;

   logic              req, mapped;
   logic [WIDX_W-1:0] widx;
   reg_idx_t          ridx;
   logic [31:0]       rmux;

   generate
      if (NPINS < 1 || NPINS > 32) begin : g_bad_pins
         $error("pbk_regs: NPINS must lie in 1..32");
      end
      if (ADR_W < 5) begin : g_bad_adr
         $error("pbk_regs: ADR_W must be at least 5");
      end
   endgenerate

   function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] old,
                                              input logic [31:0] nv,
                                              input logic [3:0] sel);
      logic [NPINS-1:0] r;
      for (int b = 0; b < NPINS; b++) r[b] = sel[b/8] ? nv[b] : old[b];
      return r;
   endfunction

   function automatic logic [31:0] widen(input logic [NPINS-1:0] v);
      logic [31:0] r;
      r = '0;
      r[NPINS-1:0] = v;
      return r;
   endfunction

   assign req    = bus_cyc && bus_stb && !bus_ack && !bus_err;
   assign widx   = bus_adr[ADR_W-1:2];
   assign mapped = (bus_adr[1:0] == 2'b00) && ((widx >> 3) == '0);
   assign ridx   = reg_idx_t'(widx[2:0]);

   assign pend_we   = req && mapped && bus_we && (ridx == RG_PEND);
   assign pend_wval = merge(pend, bus_wdat, bus_sel);

   always_comb begin
      unique case (ridx)
         RG_SAMPLE: rmux = widen(smp);
         RG_DRIVE:  rmux = widen(drive_q);
         RG_ENABLE: rmux = widen(enable_q);
         RG_IEN:    rmux = widen(ien_q);
         RG_RISE:   rmux = widen(rise_q);
         RG_ALT:    rmux = widen(alt_q);
         RG_MODE:   rmux = {28'd0, |pend, mode_q};
         RG_PEND:   rmux = widen(pend);
         default:   rmux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_ack  <= 1'b0;
         bus_err  <= 1'b0;
         bus_rdat <= '0;
         drive_q  <= '0;
         enable_q <= '0;
         ien_q    <= '0;
         rise_q   <= '0;
         alt_q    <= '0;
         mode_q   <= '0;
      end else begin
         bus_ack <= req && mapped;
         bus_err <= req && !mapped;
         if (req && mapped && !bus_we) bus_rdat <= rmux;
         if (req && mapped && bus_we) begin
            unique case (ridx)
               RG_DRIVE:  drive_q  <= merge(drive_q, bus_wdat, bus_sel);
               RG_ENABLE: enable_q <= merge(enable_q, bus_wdat, bus_sel);
               RG_IEN:    ien_q    <= merge(ien_q, bus_wdat, bus_sel);
               RG_RISE:   rise_q   <= merge(rise_q, bus_wdat, bus_sel);
               RG_ALT:    alt_q    <= merge(alt_q, bus_wdat, bus_sel);
               RG_MODE:   if (bus_sel[0]) mode_q <= bus_wdat[MODE_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   // R2: never both responses
   p_one_resp_r2: assert property (@(posedge clk) disable iff (rst)
      !(bus_ack && bus_err));

   // R2: a fresh request is answered on the next cycle
   p_resp_next_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_cyc && bus_stb && !bus_ack && !bus_err) |=> (bus_ack || bus_err));

   // R3: a full-lane write to the driver-enable register lands intact
   p_full_write_r3: assert property (@(posedge clk) disable iff (rst)
      (req && mapped && bus_we && ridx == RG_ENABLE && bus_sel == 4'hF)
      |=> (widen(enable_q) == ($past(bus_wdat) & widen('1))));

   // R11: clearing the global enable in a write takes effect next cycle
   p_ie_clear_r11: assert property (@(posedge clk) disable iff (rst)
      (req && mapped && bus_we && ridx == RG_MODE && bus_sel[0] && !bus_wdat[MB_IE])
      |=> !mode_q[MB_IE]);

endmodule

// File: rtl/pbk_top.sv
module pbk_top
   import pbk_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int ADR_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_cyc,
   input  logic             bus_stb,
   input  logic             bus_we,
   input  logic [ADR_W-1:0] bus_adr,
   input  logic [3:0]       bus_sel,
   input  logic [31:0]      bus_wdat,
   output logic [31:0]      bus_rdat,
   output logic             bus_ack,
   output logic             bus_err,
   output logic             irq,
   input  logic [NPINS-1:0] pin_i,
   input  logic [NPINS-1:0] aux_i,
   input  logic             ext_clk,
   output logic [NPINS-1:0] pad_o,
   output logic [NPINS-1:0] pad_oe_n
);

   logic [NPINS-1:0]  smp, pend, drive_q, enable_q, ien_q, rise_q, alt_q, pend_wval;
   logic [MODE_W-1:0] mode_q;
   logic              pend_we;

   pbk_regs #(.NPINS(NPINS), .ADR_W(ADR_W)) i_regs (
      .clk(clk), .rst(rst),
      .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
      .bus_sel(bus_sel), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
      .bus_ack(bus_ack), .bus_err(bus_err),
      .smp(smp), .pend(pend),
      .drive_q(drive_q), .enable_q(enable_q), .ien_q(ien_q), .rise_q(rise_q),
      .alt_q(alt_q), .mode_q(mode_q), .pend_we(pend_we), .pend_wval(pend_wval)
   );

   pbk_capture #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_capture (
      .clk(clk), .rst(rst),
      .ext_mode(mode_q[MB_EXT]), .fall_mode(mode_q[MB_FALL]),
      .ext_clk(ext_clk), .pin_i(pin_i), .smp_o(smp)
   );

   pbk_events #(.NPINS(NPINS)) i_events (
      .clk(clk), .rst(rst), .smp(smp), .ien(ien_q), .rise(rise_q),
      .pend_we(pend_we), .pend_wval(pend_wval), .pend(pend)
   );

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pad
         assign pad_o[i]    = alt_q[i] ? aux_i[i] : drive_q[i];
         assign pad_oe_n[i] = !enable_q[i];
      end
   endgenerate

   assign irq = mode_q[MB_IE] && (|pend);

   // R11: with the global enable off the request stays low
   p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
      !mode_q[MB_IE] |-> !irq);

   // R1: reset leaves the pad drivers off
   p_reset_pads_r1: assert property (@(posedge clk)
      $past(rst) |-> (pad_oe_n == '1 && !irq));

endmodule

// File: tb/test_pbk_top.sv
`timescale 1ns/1ps
module test_pbk_top;

   localparam int N = 16;

   logic          clk = 1'b0, rst = 1'b1;
   logic          bus_cyc = 0, bus_stb = 0, bus_we = 0, ext_clk = 0;
   logic [7:0]    bus_adr = '0;
   logic [3:0]    bus_sel = '0;
   logic [31:0]   bus_wdat = '0, bus_rdat;
   logic          bus_ack, bus_err, irq;
   logic [N-1:0]  pin_i = '0, aux_i = '0, pad_o, pad_oe_n;

   int   checks = 0, errors = 0;
   bit   done = 0, cur_we = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   pbk_top #(.NPINS(N), .ADR_W(8), .SYNC_STAGES(2)) i_pbk_top (
      .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
      .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
      .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq), .pin_i(pin_i), .aux_i(aux_i),
      .ext_clk(ext_clk), .pad_o(pad_o), .pad_oe_n(pad_oe_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one access, optional expected read data pushed to the scoreboard
   task automatic xfer(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] s, input string tag, input logic [31:0] exp,
                       input bit want_err);
      @(negedge clk);
      cur_we = we;
      if (!we && !want_err) begin exp_q.push_back(exp); tag_q.push_back(tag); end
      bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d; bus_sel = s;
      @(negedge clk);
      chk({"R2 response ", tag}, {30'd0, bus_ack, bus_err}, want_err ? 32'd1 : 32'd2);
      bus_cyc = 0; bus_stb = 0; bus_we = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
      xfer(1'b1, a, d, s, "write", '0, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      xfer(1'b0, a, '0, 4'hF, tag, exp, 1'b0);
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares every read completion with the scoreboard head
   always @(negedge clk) begin
      if (bus_ack && !cur_we) begin
         if (exp_q.size() == 0) chk("R2 unexpected read ack", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), bus_rdat, exp_q.pop_front());
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clks(3);
      rst = 0;
      wait_clks(1);
      // R1 reset state
      chk("R1 pad_o", 32'(pad_o), 32'h0);
      chk("R1 pad_oe_n", 32'(pad_oe_n), 32'hFFFF);
      chk("R1 irq/ack/err", {29'd0, irq, bus_ack, bus_err}, 32'h0);
      rd(8'h04, 32'h0, "R1 drive reset");
      rd(8'h18, 32'h0, "R1 mode reset");
      rd(8'h1C, 32'h0, "R1 pending reset");

      // R2 error responses
      xfer(1'b0, 8'h20, '0, 4'hF, "R2 unmapped", '0, 1'b1);
      xfer(1'b1, 8'h05, 32'hFF, 4'hF, "R2 misaligned", '0, 1'b1);
      rd(8'h04, 32'h0, "R2 misaligned write had no effect");

      // R3 byte lanes, R5 mux
      wr(8'h04, 32'h0000FFFF);
      wr(8'h04, 32'h00001234, 4'b0010);
      rd(8'h04, 32'h000012FF, "R3 byte lane merge");
      wait_clks(1);
      chk("R5 pad_o from drive", 32'(pad_o), 32'h12FF);
      aux_i = 16'hAAAA;
      wr(8'h14, 32'h000000F0);
      wait_clks(1);
      chk("R5 pad_o mixed aux", 32'(pad_o), 32'h12AF);

      // R4 enable inversion
      wr(8'h08, 32'h00000F0F);
      wait_clks(1);
      chk("R4 pad_oe_n", 32'(pad_oe_n), 32'hF0F0);

      // R6 and R12
      pin_i = 16'h5A3C;
      wait_clks(2);
      rd(8'h00, 32'h5A3C, "R6 bus-clock sampling");
      pin_i = 16'h0000;
      wr(8'h00, 32'hFFFFFFFF);
      rd(8'h00, 32'h0000, "R12 sampled register ignores writes");

      // R7 rising external edge
      wr(8'h18, 32'h1);
      pin_i = 16'hC001;
      wait_clks(6);
      rd(8'h00, 32'h0000, "R7 no edge keeps value");
      ext_clk = 1;
      wait_clks(6);
      pin_i = 16'h7777;
      wait_clks(6);
      rd(8'h00, 32'hC001, "R7 capture on rising edge only");
      ext_clk = 0;
      wait_clks(6);
      rd(8'h00, 32'hC001, "R7 falling edge ignored");

      // R8 falling edge
      wr(8'h18, 32'h3);
      ext_clk = 1;
      wait_clks(6);
      rd(8'h00, 32'hC001, "R8 rising edge ignored");
      pin_i = 16'h0BEE;
      ext_clk = 0;
      wait_clks(6);
      pin_i = 16'h1111;
      wait_clks(6);
      rd(8'h00, 32'h0BEE, "R8 capture on falling edge");

      // back to bus-clock mode with pins low
      pin_i = '0;
      wr(8'h18, 32'h0);
      wait_clks(3);

      // R9 polarity and per-pin enable, R11 latency
      wr(8'h10, 32'h0000000F);          // pins 0..3 count rises
      wr(8'h0C, 32'h00000105);          // only pins 0, 2, 8 recorded
      wr(8'h18, 32'h4);
      @(negedge clk);
      pin_i = 16'h010F;
      wait_clks(3);
      chk("R11 irq within three clocks", {31'd0, irq}, 32'd1);
      rd(8'h1C, 32'h0005, "R9 rises on enabled rise pins only");
      rd(8'h18, 32'h000C, "R11 mode flag bit");
      pin_i = 16'h0000;
      wait_clks(3);
      rd(8'h1C, 32'h0105, "R9 fall on pin 8, rise pins ignore fall");
      wait_clks(20);
      rd(8'h1C, 32'h0105, "R10 pending bits sticky");

      // R10 clear by write
      wr(8'h1C, 32'h0);
      rd(8'h1C, 32'h0, "R10 write clears");
      @(negedge clk);
      chk("R11 irq low with nothing pending", {31'd0, irq}, 32'd0);

      // R11 disabling drops irq and keeps it low
      pin_i = 16'h0001;
      wait_clks(3);
      chk("R11 irq on new event", {31'd0, irq}, 32'd1);
      wr(8'h18, 32'h0);
      chk("R11 irq dropped by mode write", {31'd0, irq}, 32'd0);
      pin_i = 16'h0000;
      wait_clks(4);
      pin_i = 16'h0001;
      wait_clks(4);
      chk("R11 irq stays low while disabled", {31'd0, irq}, 32'd0);
      rd(8'h18, 32'h0008, "R11 flag still shows pending");

      wait_clks(3);
      chk("R2 scoreboard drained", exp_q.size(), 32'd0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule